// File: doc/BRIEF.md
# Boot-Time Address Redirection Aperture

This block sits in the request path of a memory controller. It looks at the address of each client request and compares it with one programmable address window. A request whose address falls inside the window goes to a secondary port that leads to on-chip RAM over the internal bus. Every other request goes to the DRAM port. The window is meant for early boot, when storage and host-controller clients must reach on-chip RAM. Boot firmware then makes the window empty and locks it, so that range reaches DRAM for the rest of the session.

Requests enter on a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The routing decision is stored in a single output stage, and the request appears on exactly one output stream in the next cycle. The output stage holds its request until that port's ready is high. While the stage is full and the selected port is stalled, `req_ready` is low. There is one stage and there is no reordering. The window is set through a small register port with plain write and read strobes. A control register holds a sticky write lock.

Top module: `boot_aperture_router`

## Requirements
- R1: A request with base <= addr <= top is sent to the on-chip RAM port. The compare uses the full 40-bit address, and both bounds are inclusive. Here base is {base_hi, base_lo} and top is {top_hi, top_lo}.
- R2: A request whose address is outside the window is sent to the DRAM port.
- R3: After reset the window is empty, so every request goes to DRAM. Base reads 0xFFFFFFFF, top reads 0x00000000, the high register reads 0x000000FF and the control register reads 0.
- R4: When base > top the window is empty. This includes base_lo = 0xFFFFFFFF with top_lo = 0 under equal high bits, and the case where only the high bits give base > top.
- R5: The register offsets are base_lo at 0x65C, top_lo at 0x660, control at 0x964 and the high register at 0x980. In the high register, bits [7:0] hold the base high bits and bits [23:16] hold the top high bits.
- R6: A write to the control register with bit 0 = 1 sets the lock. From then on, writes to base_lo, top_lo and the high register are ignored.
- R7: The lock is sticky. Writing 0 to the control register leaves it set, and only reset clears it. The control register reads the lock in bit 0.
- R8: A read strobe returns the register's current value on `cfg_rdata` with `cfg_rvalid` high one cycle later, whether or not the lock is set. Unmapped offsets read 0.
- R9: An accepted request is presented on its port in the next cycle. It is held with its address stable until that port's ready is high. `req_ready` = stage empty OR the selected port is ready. Requests leave in the order they were accepted.
- R10: A request is routed with the window as it stood in its acceptance cycle. A register write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted when high with valid |
| req_addr | input | 40 | Incoming request address |
| ram_valid | output | 1 | Request on the on-chip RAM port |
| ram_ready | input | 1 | On-chip RAM port can take the request |
| ram_addr | output | 40 | Address on the on-chip RAM port |
| dram_valid | output | 1 | Request on the DRAM port |
| dram_ready | input | 1 | DRAM port can take the request |
| dram_addr | output | 40 | Address on the DRAM port |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
A bad window bound or a wrong lock state first shows up as a request leaving on the wrong port. This happens in the cycle right after that request is accepted, and it is also visible on the next register read-back of the same value. A lock that clears, or a write that gets through after locking, shows up at the next read of that register. It also shows up as a change in routing for addresses near the bounds. A slip in the output stage, such as a dropped, duplicated or altered held request, shows up at once on the valid, address and ready pins. The bench compares these against its own model on every clock.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int unsigned CFG_AW     = 12;
  localparam int unsigned CFG_DW     = 32;
  localparam int unsigned LO_W       = 32;
  localparam int unsigned HI_TOP_LSB = 16;

  localparam logic [CFG_AW-1:0] OFF_BASE_LO = 12'h65C;
  localparam logic [CFG_AW-1:0] OFF_TOP_LO  = 12'h660;
  localparam logic [CFG_AW-1:0] OFF_LOCK    = 12'h964;
  localparam logic [CFG_AW-1:0] OFF_HI      = 12'h980;

  localparam int unsigned PORT_DRAM = 0;
  localparam int unsigned PORT_RAM  = 1;
  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/bar_regfile.sv
module bar_regfile
  import bar_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_top,
  output logic              locked
);
  // High part must fit in [HI_TOP_LSB-1:0] and [HI_TOP_LSB +: HI_W]
  localparam int unsigned HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0]   base_lo_q, top_lo_q;
  logic [HI_W-1:0]   base_hi_q, top_hi_q;
  logic              lock_q;
  logic              wr_open;
  logic [CFG_DW-1:0] hi_word;
  logic [CFG_DW-1:0] rd_mux;

  assign wr_open = cfg_wr && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '1;
      base_hi_q <= '1;
      top_lo_q  <= '0;
      top_hi_q  <= '0;
    end else if (wr_open) begin
      case (cfg_addr)
        OFF_BASE_LO: base_lo_q <= cfg_wdata[LO_W-1:0];
        OFF_TOP_LO:  top_lo_q  <= cfg_wdata[LO_W-1:0];
        OFF_HI: begin
          base_hi_q <= cfg_wdata[HI_W-1:0];
          top_hi_q  <= cfg_wdata[HI_TOP_LSB +: HI_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (cfg_wr && (cfg_addr == OFF_LOCK) && cfg_wdata[0]) begin
      lock_q <= 1'b1;
    end
  end

  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = base_hi_q;
    hi_word[HI_TOP_LSB +: HI_W] = top_hi_q;
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      OFF_BASE_LO: rd_mux = base_lo_q;
      OFF_TOP_LO:  rd_mux = top_lo_q;
      OFF_HI:      rd_mux = hi_word;
      OFF_LOCK:    rd_mux = {{(CFG_DW-1){1'b0}}, lock_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_mux;
    end
  end

  assign win_base = {base_hi_q, base_lo_q};
  assign win_top  = {top_hi_q, top_lo_q};
  assign locked   = lock_q;

  // R7: once set, the lock never drops before reset
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R6: window registers frozen while locked
  p_frozen_when_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(base_lo_q) && $stable(top_lo_q)
                && $stable(base_hi_q) && $stable(top_hi_q)));

  // R6: a control write with bit 0 set leaves the block locked
  p_lock_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_addr == OFF_LOCK) && cfg_wdata[0]) |=> locked);

  // R8: read strobe answered in the next cycle
  p_read_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);
endmodule

// File: rtl/bar_window_cmp.sv
module bar_window_cmp #(
  parameter int unsigned ADDR_W        = 40,
  parameter bit          TOP_INCLUSIVE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] top,
  output logic              hit
);
  logic above_base;
  logic below_top;

  assign above_base = (addr >= base);

  generate
    if (TOP_INCLUSIVE) begin : g_top_incl
      assign below_top = (addr <= top);
    end else begin : g_top_excl
      assign below_top = (addr < top);
    end
  endgenerate

  // base > top can satisfy neither bound at once, so the window is empty
  assign hit = above_base && below_top;
endmodule

// File: rtl/bar_route_stage.sv
module bar_route_stage
  import bar_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic                 in_to_ram,
  output logic [NUM_PORTS-1:0] out_valid,
  input  logic [NUM_PORTS-1:0] out_ready,
  output logic [ADDR_W-1:0]    out_addr
);
  logic              q_valid;
  logic              q_to_ram;
  logic [ADDR_W-1:0] q_addr;
  logic              sel_ready;
  logic              out_fire;
  logic              in_fire;

  assign sel_ready = q_to_ram ? out_ready[PORT_RAM] : out_ready[PORT_DRAM];
  assign out_fire  = q_valid && sel_ready;
  assign in_ready  = !q_valid || sel_ready;
  assign in_fire   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_to_ram <= 1'b0;
      q_addr   <= '0;
    end else if (in_fire) begin
      q_valid  <= 1'b1;
      q_to_ram <= in_to_ram;
      q_addr   <= in_addr;
    end else if (out_fire) begin
      q_valid  <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == PORT_RAM) begin : g_ram
      assign out_valid[p] = q_valid && q_to_ram;
    end else begin : g_dram
      assign out_valid[p] = q_valid && !q_to_ram;
    end
  end

  assign out_addr = q_addr;

  // R9: a stalled entry stays put
  p_hold_when_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !out_fire) |=> (q_valid && $stable(q_addr) && $stable(q_to_ram)));

  // R9: an accepted request is presented next cycle
  p_accept_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> ($countones(out_valid) == 1 && out_addr == $past(in_addr)));
endmodule

// File: rtl/boot_aperture_router.sv
module boot_aperture_router
  import bar_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              dram_valid,
  input  logic              dram_ready,
  output logic [ADDR_W-1:0] dram_addr,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              cfg_rvalid
);
  logic [ADDR_W-1:0]    win_base, win_top;
  logic                 win_locked;
  logic                 win_hit;
  logic [NUM_PORTS-1:0] port_valid;
  logic [NUM_PORTS-1:0] port_ready;
  logic [ADDR_W-1:0]    port_addr;

  bar_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cfg_rvalid (cfg_rvalid),
    .win_base   (win_base),
    .win_top    (win_top),
    .locked     (win_locked)
  );

  bar_window_cmp #(.ADDR_W(ADDR_W), .TOP_INCLUSIVE(1'b1)) u_cmp (
    .addr (req_addr),
    .base (win_base),
    .top  (win_top),
    .hit  (win_hit)
  );

  assign port_ready[PORT_RAM]  = ram_ready;
  assign port_ready[PORT_DRAM] = dram_ready;

  bar_route_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (req_addr),
    .in_to_ram (win_hit),
    .out_valid (port_valid),
    .out_ready (port_ready),
    .out_addr  (port_addr)
  );

  assign ram_valid  = port_valid[PORT_RAM];
  assign dram_valid = port_valid[PORT_DRAM];
  assign ram_addr   = port_addr;
  assign dram_addr  = port_addr;

  // R1: window hit at acceptance lands on the RAM port
  p_hit_to_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && win_hit) |=> (ram_valid && ram_addr == $past(req_addr)));

  // R2: a miss lands on the DRAM port
  p_miss_to_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !win_hit) |=> (dram_valid && dram_addr == $past(req_addr)));

  // R4: inverted bounds never hit
  p_inverted_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base > win_top) |-> !win_hit);

  // R9: stalled port output stays stable
  p_ram_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && !ram_ready) |=> (ram_valid && $stable(ram_addr)));
  p_dram_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_valid && !dram_ready) |=> (dram_valid && $stable(dram_addr)));
endmodule

// File: tb/boot_aperture_router_tb_top.sv
`timescale 1ns/1ps
module boot_aperture_router_tb_top;
  localparam logic [11:0] A_BASE = 12'h65C;
  localparam logic [11:0] A_TOP  = 12'h660;
  localparam logic [11:0] A_LOCK = 12'h964;
  localparam logic [11:0] A_HI   = 12'h980;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        ram_valid, dram_valid;
  logic        ram_ready = 1'b1, dram_ready = 1'b1;
  logic [39:0] ram_addr, dram_addr;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  boot_aperture_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr),
    .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_addr(dram_addr),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
  );

  // ---------------- reference model ----------------
  logic [31:0] mb_lo, mt_lo;
  logic [7:0]  mb_hi, mt_hi;
  bit          m_lock;
  bit          m_sv, m_sram;
  logic [39:0] m_saddr;
  bit          m_rv;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      A_BASE:  return mb_lo;
      A_TOP:   return mt_lo;
      A_HI:    return {8'h00, mt_hi, 8'h00, mb_hi};
      A_LOCK:  return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit model_hit(input logic [39:0] a);
    return ({mb_hi, mb_lo} <= a) && (a <= {mt_hi, mt_lo});
  endfunction

  function automatic bit model_ready();
    return !m_sv || (m_sram ? ram_ready : dram_ready);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mb_lo = '1; mb_hi = '1; mt_lo = '0; mt_hi = '0;
      m_lock = 1'b0; m_sv = 1'b0; m_sram = 1'b0; m_saddr = '0;
      m_rv = 1'b0; m_rd = '0;
    end else begin
      bit rdy;
      bit hit_now;
      rdy = model_ready();
      hit_now = model_hit(req_addr);
      if (m_sv && rdy) m_sv = 1'b0;
      if (req_valid && rdy) begin
        m_sv = 1'b1; m_saddr = req_addr; m_sram = hit_now;
      end
      if (cfg_rd) m_rd = model_read(cfg_addr);
      m_rv = cfg_rd;
      if (cfg_wr) begin
        if (!m_lock) begin
          if (cfg_addr == A_BASE) mb_lo = cfg_wdata;
          if (cfg_addr == A_TOP)  mt_lo = cfg_wdata;
          if (cfg_addr == A_HI) begin
            mb_hi = cfg_wdata[7:0]; mt_hi = cfg_wdata[23:16];
          end
        end
        if (cfg_addr == A_LOCK && cfg_wdata[0]) m_lock = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    #1;
    if (cycles > 0 && !done) begin
      check(req_ready == model_ready(), "R9 req_ready", 64'(req_ready), 64'(model_ready()));
      check(ram_valid == (m_sv && m_sram), "R1 ram_valid", 64'(ram_valid), 64'(m_sv && m_sram));
      check(dram_valid == (m_sv && !m_sram), "R2 dram_valid", 64'(dram_valid), 64'(m_sv && !m_sram));
      if (m_sv) begin
        check((m_sram ? ram_addr : dram_addr) == m_saddr, "R9 port address",
              64'(m_sram ? ram_addr : dram_addr), 64'(m_saddr));
      end
      check(cfg_rvalid == m_rv, "R8 cfg_rvalid", 64'(cfg_rvalid), 64'(m_rv));
      if (m_rv) check(cfg_rdata == m_rd, "R8 cfg_rdata", 64'(cfg_rdata), 64'(m_rd));
    end
  end

  // random back-pressure
  always @(negedge clk) begin
    if (bp_en) begin
      ram_ready  = ($urandom % 4) != 0;
      dram_ready = ($urandom % 3) != 0;
    end else begin
      ram_ready  = 1'b1;
      dram_ready = 1'b1;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_expect(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    #1;
    check(cfg_rvalid && cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic send(input logic [39:0] a);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    do begin
      #1 ok = req_ready;
      @(negedge clk);
    end while (!ok);
    req_valid = 1'b0;
  endtask

  task automatic send_expect(input logic [39:0] a, input bit to_ram, input string req);
    send(a);
    #1;
    if (to_ram) check(ram_valid && ram_addr == a, req, {ram_valid, 23'd0, ram_addr}, {1'b1, 23'd0, a});
    else        check(dram_valid && dram_addr == a, req, {dram_valid, 23'd0, dram_addr}, {1'b1, 23'd0, a});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1'b1;
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state and R5 layout
    read_expect(A_BASE, 32'hFFFF_FFFF, "R3 base_lo reset");
    read_expect(A_TOP,  32'h0000_0000, "R3 top_lo reset");
    read_expect(A_HI,   32'h0000_00FF, "R3 R5 high reg reset");
    read_expect(A_LOCK, 32'h0, "R3 lock reset");
    send_expect(40'h00_0000_0000, 1'b0, "R3 empty after reset");
    send_expect(40'hFF_FFFF_FFFF, 1'b0, "R3 empty after reset top");

    // R1 R2 R5 programmed window [3_00001000 .. 3_00001FFF]
    cfg_write(A_HI, 32'h0003_0003);
    cfg_write(A_BASE, 32'h0000_1000);
    cfg_write(A_TOP, 32'h0000_1FFF);
    read_expect(A_HI, 32'h0003_0003, "R5 high reg fields");
    send_expect(40'h03_0000_1000, 1'b1, "R1 lower bound");
    send_expect(40'h03_0000_1FFF, 1'b1, "R1 upper bound");
    send_expect(40'h03_0000_0FFF, 1'b0, "R2 below base");
    send_expect(40'h03_0000_2000, 1'b0, "R2 above top");
    send_expect(40'h02_0000_1500, 1'b0, "R1 high bits compared");

    // R10 write on the acceptance edge does not affect that request
    @(negedge clk);
    req_valid = 1'b1; req_addr = 40'h03_0000_1800;
    cfg_wr = 1'b1; cfg_addr = A_TOP; cfg_wdata = 32'h0000_0FFF;
    @(negedge clk);
    req_valid = 1'b0; cfg_wr = 1'b0;
    #1 check(ram_valid && ram_addr == 40'h03_0000_1800, "R10 old window used",
             64'(ram_valid), 64'd1);
    send_expect(40'h03_0000_1800, 1'b0, "R10 new window for later request");

    // R4 emptied window
    cfg_write(A_HI, 32'h0);
    cfg_write(A_BASE, 32'hFFFF_FFFF);
    cfg_write(A_TOP, 32'h0);
    send_expect(40'h00_0000_0000, 1'b0, "R4 empty low");
    send_expect(40'h00_8000_0000, 1'b0, "R4 empty mid");
    send_expect(40'h00_FFFF_FFFF, 1'b0, "R4 empty high");
    cfg_write(A_HI, 32'h0004_0005);
    cfg_write(A_BASE, 32'h0);
    cfg_write(A_TOP, 32'hFFFF_FFFF);
    send_expect(40'h04_8000_0000, 1'b0, "R4 inverted by high bits");
    send_expect(40'h05_0000_0000, 1'b0, "R4 inverted by high bits 2");

    // R8 unmapped read
    read_expect(12'h100, 32'h0, "R8 unmapped reads zero");

    // R6 R7 lock
    cfg_write(A_HI, 32'h0002_0002);
    cfg_write(A_BASE, 32'h0000_0040);
    cfg_write(A_TOP, 32'h0000_007F);
    cfg_write(A_LOCK, 32'h1);
    cfg_write(A_BASE, 32'h0);
    cfg_write(A_TOP, 32'hFFFF_FFFF);
    cfg_write(A_HI, 32'h00FF_0000);
    read_expect(A_BASE, 32'h0000_0040, "R6 base frozen");
    read_expect(A_TOP,  32'h0000_007F, "R6 top frozen");
    read_expect(A_HI,   32'h0002_0002, "R6 high frozen");
    cfg_write(A_LOCK, 32'h0);
    read_expect(A_LOCK, 32'h1, "R7 lock sticky");
    send_expect(40'h02_0000_0040, 1'b1, "R6 locked window hit low");
    send_expect(40'h02_0000_007F, 1'b1, "R6 locked window hit high");
    send_expect(40'h02_0000_0080, 1'b0, "R6 locked window miss");
    send_expect(40'h02_0000_003F, 1'b0, "R6 locked window miss below");

    // R9 back-pressure with mixed traffic, checked by the model each cycle
    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [39:0] a;
      a = {8'h02, 24'd0, 8'($urandom)};
      if (i % 5 == 0) a = {8'($urandom % 4), 32'($urandom)};
      send(a);
    end
    bp_en = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule